// File: doc/BRIEF.md
# Configurable Serial Baud Rate Generator

This block produces the timing pulses for a serial port. A down-counter reloads from a divisor value n and emits a one-cycle base tick every n+1 clocks. A prescaler then divides those base ticks by 64, 16 or 4 to form a one-cycle bit-rate tick. Three mode inputs pick the prescale factor and the counter width: synchronous operation, a wide (16-bit) divisor, and high-speed select.

Software-facing logic writes the divisor as two bytes, each with its own strobe. Any divisor write, and any change of a mode input, restarts both the counter and the prescaler at once. The new rate therefore applies from the clock edge that takes the change, and the old period is not completed first. For example, with a 16 MHz clock, 8-bit asynchronous normal-speed operation and n=25, the bit tick rate is 16e6/(64·26), about 9615 per second.

Top module: `baud_rate_gen`

## Requirements
- R1: While `rst` is high both tick outputs are low. Reset leaves divisor bytes at 0 and mode registers at 0, so after reset with all mode inputs low a bit tick occurs every 64 clocks.
- R2: With `mode_wide`=0 the divisor is the low byte only; the high byte has no effect on either tick.
- R3: With `mode_wide`=1 the divisor is n = {high byte, low byte}, a 16-bit value.
- R4: With `mode_sync`=0, `mode_wide`=0 and `mode_fast`=0 the bit tick period is 64·(n+1) clocks.
- R5: With `mode_sync`=0 and exactly one of `mode_wide`, `mode_fast` set, the bit tick period is 16·(n+1) clocks.
- R6: With `mode_sync`=0, `mode_wide`=1 and `mode_fast`=1 the bit tick period is 4·(n+1) clocks.
- R7: With `mode_sync`=1 the bit tick period is 4·(n+1) clocks for both widths; `mode_fast` has no effect.
- R8: `base_tick` is a one-cycle pulse every n+1 clocks; with n=0 it is high on every clock and never stalls.
- R9: A divisor write sampled at clock edge E restarts the timing: the first `base_tick` falls n cycles after E, and the first `bit_tick` falls F·(n+1)−1 cycles after E, where F is the prescale factor. No tick from the old period appears in between.
- R10: A change of any mode input sampled at edge E restarts the timing in the same way as R9, using the new mode.
- R11: `bit_tick` is high for a single cycle and only in a cycle where `base_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_lo_data | input | 8 | Low divisor byte |
| div_lo_wr | input | 1 | Write strobe for the low byte |
| div_hi_data | input | 8 | High divisor byte |
| div_hi_wr | input | 1 | Write strobe for the high byte |
| mode_sync | input | 1 | Synchronous operation select |
| mode_wide | input | 1 | 16-bit divisor enable |
| mode_fast | input | 1 | High-speed select (asynchronous only) |
| base_tick | output | 1 | One-cycle pulse every n+1 clocks |
| bit_tick | output | 1 | One-cycle bit-rate pulse every F·(n+1) clocks |

## Verification
Both ticks come from combinational decodes of registers that load at the restart edge. After a stimulus taken at edge E, the first base tick is visible n cycles later and the first bit tick F·(n+1)−1 cycles later. The bench drives inputs on the falling edge and holds the strobes for exactly one cycle. It then counts falling edges from the restart edge and compares the exact cycle index of the first tick against these figures. After that it counts the full period to the next tick. Because the first tick position is checked exactly, a tick left over from an earlier configuration shows up as a mismatch.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIV_W  = 7;   // holds prescale factors up to 64

  // Prescale factor chosen by the three mode bits.
  function automatic logic [DIV_W-1:0] prescale_div(input logic sync_m,
                                                     input logic wide_m,
                                                     input logic fast_m);
    if (sync_m)               return DIV_W'(4);
    else if (wide_m && fast_m) return DIV_W'(4);
    else if (wide_m ^ fast_m)  return DIV_W'(16);
    else                       return DIV_W'(64);
  endfunction

  // Effective divisor: narrow mode ignores the high byte.
  function automatic logic [CNT_W-1:0] eff_divisor(input logic wide_m,
                                                    input logic [BYTE_W-1:0] hi,
                                                    input logic [BYTE_W-1:0] lo);
    return wide_m ? {hi, lo} : {{BYTE_W{1'b0}}, lo};
  endfunction
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int CW = 2 * BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BW-1:0]    lo_data,
  input  logic             lo_wr,
  input  logic [BW-1:0]    hi_data,
  input  logic             hi_wr,
  input  logic             sync_in,
  input  logic             wide_in,
  input  logic             fast_in,
  output logic [CW-1:0]    n_cur,
  output logic [CW-1:0]    n_next,
  output logic [DIV_W-1:0] div_cur,
  output logic             restart
);
  logic [BW-1:0] lo_q, hi_q;
  logic [2:0]    mode_q;
  logic [BW-1:0] lo_nx, hi_nx;
  logic          mode_chg;

  assign mode_chg = ({sync_in, wide_in, fast_in} != mode_q);
  assign restart  = !rst && (lo_wr || hi_wr || mode_chg);
  assign lo_nx    = lo_wr ? lo_data : lo_q;
  assign hi_nx    = hi_wr ? hi_data : hi_q;
  assign n_next   = CW'(eff_divisor(wide_in, BYTE_W'(hi_nx), BYTE_W'(lo_nx)));
  assign n_cur    = CW'(eff_divisor(mode_q[1], BYTE_W'(hi_q), BYTE_W'(lo_q)));
  assign div_cur  = prescale_div(mode_q[2], mode_q[1], mode_q[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= '0;
    end else begin
      lo_q   <= lo_nx;
      hi_q   <= hi_nx;
      mode_q <= {sync_in, wide_in, fast_in};
    end
  end

  // R10
  mode_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (mode_q == $past({sync_in, wide_in, fast_in})));
endmodule

// File: rtl/baud_core_cnt.sv
module baud_core_cnt #(
  parameter int CW = baud_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] n_next,
  input  logic [CW-1:0] n_cur,
  output logic          core_tick
);
  logic [CW-1:0] cnt;

  assign core_tick = !rst && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (restart)   cnt <= n_next;
    else if (cnt == '0) cnt <= n_cur;
    else                cnt <= cnt - 1'b1;
  end

  // R9
  restart_load_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == $past(n_next)));
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= n_cur);
  // R8
  zero_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (n_cur == '0 && $past(n_cur == '0) && !$past(rst) && !restart) |-> core_tick);
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DW = baud_pkg::DIV_W,
  localparam int PW = DW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          core_tick,
  input  logic [DW-1:0] div_cur,
  output logic          bit_tick
);
  logic [PW-1:0] pcnt;
  logic          last;

  assign last     = ({1'b0, pcnt} == div_cur - 1'b1);
  assign bit_tick = core_tick && last;

  always_ff @(posedge clk) begin
    if (rst || restart)  pcnt <= '0;
    else if (core_tick)  pcnt <= last ? '0 : pcnt + 1'b1;
  end

  // R11
  bit_in_base_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> core_tick);
  // R11
  bit_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);
  // R9
  pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] div_lo_data,
  input  logic              div_lo_wr,
  input  logic [BYTE_W-1:0] div_hi_data,
  input  logic              div_hi_wr,
  input  logic              mode_sync,
  input  logic              mode_wide,
  input  logic              mode_fast,
  output logic              base_tick,
  output logic              bit_tick
);
  logic [CNT_W-1:0] n_cur, n_next;
  logic [DIV_W-1:0] div_cur;
  logic             restart;

  baud_cfg_regs #(.BW(BYTE_W)) u_cfg (
    .clk(clk), .rst(rst),
    .lo_data(div_lo_data), .lo_wr(div_lo_wr),
    .hi_data(div_hi_data), .hi_wr(div_hi_wr),
    .sync_in(mode_sync), .wide_in(mode_wide), .fast_in(mode_fast),
    .n_cur(n_cur), .n_next(n_next), .div_cur(div_cur), .restart(restart)
  );

  baud_core_cnt #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart),
    .n_next(n_next), .n_cur(n_cur), .core_tick(base_tick)
  );

  baud_prescaler #(.DW(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart),
    .core_tick(base_tick), .div_cur(div_cur), .bit_tick(bit_tick)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (!base_tick && !bit_tick));
endmodule

// File: tb/baud_rate_gen_tb.sv
module baud_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 300000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] lo_d = '0, hi_d = '0;
  logic lo_w = 1'b0, hi_w = 1'b0;
  logic m_sync = 1'b0, m_wide = 1'b0, m_fast = 1'b0;
  logic base_tick, bit_tick;
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_rate_gen u_dut (
    .clk(clk), .rst(rst),
    .div_lo_data(lo_d), .div_lo_wr(lo_w),
    .div_hi_data(hi_d), .div_hi_wr(hi_w),
    .mode_sync(m_sync), .mode_wide(m_wide), .mode_fast(m_fast),
    .base_tick(base_tick), .bit_tick(bit_tick)
  );

  function automatic int factor(bit s, bit w, bit f);
    case ({s, w, f})
      3'b000:                   return 64;
      3'b001, 3'b010:           return 16;
      default:                  return 4;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply a configuration (write strobes optional) and check first-tick
  // latency, then the period, then single-cycle width.
  task automatic run_cfg(string req, bit wr_lo, bit wr_hi, logic [7:0] lo,
                         logic [7:0] hi, bit s, bit w, bit f, int n);
    int k = 0;
    int p = 0;
    int fct = factor(s, w, f);
    @(negedge clk);
    lo_d = lo; hi_d = hi; lo_w = wr_lo; hi_w = wr_hi;
    m_sync = s; m_wide = w; m_fast = f;
    @(negedge clk);
    lo_w = 1'b0; hi_w = 1'b0;
    while (!bit_tick && k < LIMIT) begin @(negedge clk); k++; end
    check({req, " first bit tick"}, k, fct * (n + 1) - 1);
    check({req, " base with bit"}, int'(base_tick), 1);
    do begin @(negedge clk); p++; end while (!bit_tick && p < LIMIT);
    check({req, " bit period"}, p, fct * (n + 1));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 base low in reset", int'(base_tick), 0);
    check("R1 bit low in reset", int'(bit_tick), 0);
    @(negedge clk); rst = 1'b0;
    begin
      int k = 0;
      int p = 0;
      while (!bit_tick && k < 1000) begin @(negedge clk); k++; end
      check("R1 first tick after reset", k, 63);
      do begin @(negedge clk); p++; end while (!bit_tick && p < 1000);
      check("R1 default period", p, 64);
    end
  endtask

  task automatic t_zero_divisor;
    int hi_cnt = 0;
    run_cfg("R8 n=0 sync", 1, 1, 8'h00, 8'h00, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) begin
      if (base_tick) hi_cnt++;
      @(negedge clk);
    end
    check("R8 n=0 base every clock", hi_cnt, 10);
  endtask

  task automatic t_base_period;
    int p = 0;
    run_cfg("R8 n=9 async", 1, 0, 8'd9, 8'h00, 0, 1, 1, 9);
    @(negedge clk); p = 1;
    check("R11 bit one cycle", int'(bit_tick), 0);
    while (!base_tick && p < 100) begin @(negedge clk); p++; end
    check("R8 base period n=9", p, 10);
  endtask

  task automatic t_big_wide;
    int k = 0;
    @(negedge clk);
    lo_d = 8'hFF; hi_d = 8'hFF; lo_w = 1'b1; hi_w = 1'b1;
    m_sync = 1'b1; m_wide = 1'b1; m_fast = 1'b0;
    @(negedge clk);
    lo_w = 1'b0; hi_w = 1'b0;
    while (!base_tick && k < LIMIT) begin @(negedge clk); k++; end
    check("R3 n=0xFFFF first base tick", k, 65535);
  endtask

  task automatic t_mode_change;
    run_cfg("R4 n=10 base", 1, 0, 8'd10, 8'h00, 0, 0, 0, 10);
    repeat (300) @(negedge clk);
    run_cfg("R10 mode change to fast", 0, 0, 8'd10, 8'h00, 0, 0, 1, 10);
  endtask

  task automatic t_write_restart;
    run_cfg("R9 n=200 base", 1, 0, 8'd200, 8'h00, 0, 0, 0, 200);
    repeat (100) @(negedge clk);
    run_cfg("R9 rewrite low mid-period", 1, 0, 8'd5, 8'h00, 0, 0, 0, 5);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_cfg("R4 n=25 async 8-bit normal", 1, 1, 8'd25, 8'h00, 0, 0, 0, 25);
    run_cfg("R5 n=25 async 8-bit fast", 1, 0, 8'd25, 8'h00, 0, 0, 1, 25);
    run_cfg("R5 n=25 async wide normal", 1, 1, 8'd25, 8'h00, 0, 1, 0, 25);
    run_cfg("R6 n=25 async wide fast", 1, 1, 8'd25, 8'h00, 0, 1, 1, 25);
    run_cfg("R7 n=25 sync 8-bit fast0", 1, 1, 8'd25, 8'h00, 1, 0, 0, 25);
    run_cfg("R7 n=25 sync 8-bit fast1", 1, 1, 8'd25, 8'h00, 1, 0, 1, 25);
    run_cfg("R7 n=25 sync wide fast1", 1, 1, 8'd25, 8'h00, 1, 1, 1, 25);
    run_cfg("R2 high byte ignored narrow", 1, 1, 8'd3, 8'h01, 0, 0, 0, 3);
    run_cfg("R3 wide n=0x0102", 1, 1, 8'h02, 8'h01, 0, 1, 0, 258);
    t_zero_divisor();
    t_base_period();
    t_mode_change();
    t_write_restart();
    t_big_wide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule